// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block controls a bank of general-purpose pins through a plain read/write register bus. Every pin has one 32-bit configuration word. The word sets how the pin behaves: as an input, as a driven output, as one of five interrupt detectors, or with interrupts switched off. The same word carries a two-bit alternate-function number, which goes out on a per-pin select output, an input-enable bit and a three-bit group number. A read of bit 0 returns the synchronised pin level. In output mode, the bit 0 last written drives the pin.

Each pin input passes through a two-flop synchroniser. Detection then runs on the synchronised level, and an edge is found by comparing the new sample with the previous one. A detected event sets a pending bit for the pin. The pending bits appear in 32-bit status words, chosen by the pin's group and by which block of 32 pins it belongs to. Software clears a status bit by writing a one to it. A single interrupt output is high whenever any pending bit is set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration word and every status word reads 0, and `irq`, `pad_oe` and `pin_func` are all 0.
- R2: The configuration word of pin p is at byte offset 4*p. Its fields are: bits 3:1 mode, bits 6:5 function, bit 9 input enable, bits 18:16 group. These fields read back as written, and every other bit reads 0 except bit 0. Bit 0 reads the pin level two clock edges after the pin changes.
- R3: Mode code 1 (output) drives `pad_oe` high and `pad_out` with the written bit 0. With any other mode code, `pad_oe` is low.
- R4: `pin_func[2p+1:2p]` always equals bits 6:5 of pin p's configuration word.
- R5: Level modes use code 2 (high) and code 3 (low). While the level is active and input enable is set, the pending bit is set again on every cycle, so a clear takes effect only once the level is inactive.
- R6: Edge modes use code 4 (rising), code 5 (falling) and code 6 (either edge). A detected edge sets the pending bit on the third clock edge after the pin changes. The bit then stays set after the pin returns, until software clears it.
- R7: No pending bit is set when input enable (bit 9) is 0. No pending bit is set with mode code 0, 1 or 7.
- R8: Pin p's pending bit appears at bit p mod 32 of the status word at byte offset 0x800 + 64*g + 4*(p/32), where g is the pin's group field. It reads 0 in the status words of every other group.
- R9: A write to a status word clears the pending bits where the written data has a one. Pending bits where the written data has a zero stay set.
- R10: `irq` is high exactly when at least one pending bit is set.
- R11: Reads of unmapped offsets return 0, and writes to them change no state. Unmapped offsets are: configuration words beyond the last pin, status words beyond the last 32-pin block, offsets from 0xA00 upward, and unaligned offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| pad_in | input | NUM_PINS | Asynchronous pin levels |
| pad_out | output | NUM_PINS | Output level per pin |
| pad_oe | output | NUM_PINS | Output enable per pin |
| pin_func | output | 2*NUM_PINS | Alternate-function select, two bits per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Bad state shows up at the ports in different ways:
- A corrupted configuration field shows at once on `pad_oe`, `pad_out` or `pin_func`, and on the next bus read.
- A bad synchroniser or edge register moves the pending bit by a cycle. The bench measures this on `irq` at the second and the third edge after a pin change.
- A pending bit routed to the wrong group or word reads as zero at its own address and as one somewhere else. Reading neighbouring status words exposes this.
- A faulty clear priority shows as a level bit that vanishes while the level is still held.

// File: rtl/gpio_irq_pkg.sv
// Shared types for the pin controller: the mode codes, the stored
// configuration fields, and the packing of a configuration read word.
// Assumes a 32-bit register bus.
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        MD_IN     = 3'd0,
        MD_OUT    = 3'd1,
        MD_LVL_HI = 3'd2,
        MD_LVL_LO = 3'd3,
        MD_RISE   = 3'd4,
        MD_FALL   = 3'd5,
        MD_BOTH   = 3'd6,
        MD_OFF    = 3'd7
    } pin_mode_e;

    typedef struct packed {
        logic [2:0] grp;
        logic       ien;
        logic [1:0] func;
        pin_mode_e  mode;
        logic       dout;
    } pin_cfg_t;

    // Build the word a configuration read returns.
    function automatic logic [31:0] pack_cfg(pin_cfg_t c, logic din);
        logic [31:0] w;
        w        = '0;
        w[0]     = din;
        w[3:1]   = c.mode;
        w[6:5]   = c.func;
        w[9]     = c.ien;
        w[18:16] = c.grp;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs, plus one
// more register that holds the previous synchronised sample for edge
// detection. Assumes each bit is independent (no bus coherency needed).
module gpio_in_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_now,
    output logic [WIDTH-1:0] sync_prev
);

    logic [WIDTH-1:0] meta_q;

    // Resolve metastability, then keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q    <= '0;
            sync_now  <= '0;
            sync_prev <= '0;
        end else begin
            meta_q    <= async_in;
            sync_now  <= meta_q;
            sync_prev <= sync_now;
        end
    end

endmodule

// File: rtl/gpio_pin_slice.sv
// One pin: its configuration register, its event detector and its pending
// bit. Assumes the inputs are already synchronised. A new event wins over a
// clear in the same cycle.
module gpio_pin_slice
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wval,
    input  logic     pend_clr,
    input  logic     in_now,
    input  logic     in_prev,
    output pin_cfg_t cfg_q,
    output logic     pend_q
);

    logic hit;

    // Hold the configuration written over the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wval;
    end

    // Decide whether the current sample pair is an event for this mode.
    always_comb begin
        unique case (cfg_q.mode)
            MD_LVL_HI: hit = in_now;
            MD_LVL_LO: hit = !in_now;
            MD_RISE:   hit = in_now && !in_prev;
            MD_FALL:   hit = !in_now && in_prev;
            MD_BOTH:   hit = in_now ^ in_prev;
            default:   hit = 1'b0;
        endcase
    end

    // Pending bit: set on a gated event, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else if (hit && cfg_q.ien) pend_q <= 1'b1;
        else if (pend_clr) pend_q <= 1'b0;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the pin controller: address decode, per-pin slices, read mux and
// the combined interrupt. Assumes the status region starts at 0x800 and is
// 512 bytes long, so group and word come straight from address bits 8:6
// and 5:2. NUM_PINS is limited to 512 so configuration words stay below it.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [2*NUM_PINS-1:0] pin_func,
    output logic                  irq
);

    localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
    localparam logic [ADDR_W-1:0] CFG_END   = ADDR_W'(NUM_PINS * 4);
    localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'(12'h800);
    localparam logic [ADDR_W-1:0] STAT_END  = ADDR_W'(12'hA00);
    localparam logic [4:0]        WORDS5    = 5'(NUM_WORDS);

    logic [NUM_PINS-1:0] in_now, in_prev, pend, ien_vec;
    logic [NUM_PINS-1:0] cfg_we, pend_clr;
    pin_cfg_t            cfg_q [NUM_PINS];
    pin_cfg_t            cfg_wval;
    logic                aligned, cfg_hit, stat_hit, wr;
    logic [ADDR_W-3:0]   word_idx;
    logic [2:0]          st_grp;
    logic [3:0]          st_word;

    // Decode the offset into a configuration or status access.
    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        word_idx = bus_addr[ADDR_W-1:2];
        st_grp   = bus_addr[8:6];
        st_word  = bus_addr[5:2];
        cfg_hit  = aligned && (bus_addr < CFG_END) && (bus_addr < STAT_BASE);
        stat_hit = aligned && (bus_addr >= STAT_BASE) && (bus_addr < STAT_END)
                   && ({1'b0, st_word} < WORDS5);
        wr       = bus_sel && bus_we;
        cfg_wval = '{grp:  bus_wdata[18:16],
                     ien:  bus_wdata[9],
                     func: bus_wdata[6:5],
                     mode: pin_mode_e'(bus_wdata[3:1]),
                     dout: bus_wdata[0]};
    end

    gpio_in_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_now (in_now),
        .sync_prev(in_prev)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign cfg_we[p]   = wr && cfg_hit && (word_idx == (ADDR_W-2)'(p));
        assign pend_clr[p] = wr && stat_hit && (st_grp == cfg_q[p].grp)
                             && (st_word == 4'(p / 32)) && bus_wdata[p % 32];

        gpio_pin_slice slice_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we[p]),
            .cfg_wval(cfg_wval),
            .pend_clr(pend_clr[p]),
            .in_now  (in_now[p]),
            .in_prev (in_prev[p]),
            .cfg_q   (cfg_q[p]),
            .pend_q  (pend[p])
        );

        assign pad_out[p]        = cfg_q[p].dout;
        assign pad_oe[p]         = (cfg_q[p].mode == MD_OUT);
        assign pin_func[2*p +: 2] = cfg_q[p].func;
        assign ien_vec[p]        = cfg_q[p].ien;
    end

    // Return the addressed configuration or status word, else zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && cfg_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (word_idx == (ADDR_W-2)'(p)) bus_rdata = pack_cfg(cfg_q[p], in_now[p]);
            end
        end else if (bus_sel && stat_hit) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if ((st_word == 4'(p / 32)) && (st_grp == cfg_q[p].grp))
                    bus_rdata[p % 32] = pend[p];
            end
        end
    end

    assign irq = |pend;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Checker for gpio_irq_ctrl, bound to every instance. It watches the pin
// outputs, the interrupt and the pending state against bus activity.
module gpio_irq_ctrl_chk #(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_rdata,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [2*NUM_PINS-1:0] pin_func,
    input logic                  irq,
    input logic [NUM_PINS-1:0]   pend,
    input logic [NUM_PINS-1:0]   ien_vec
);

    localparam logic [ADDR_W-1:0] GAP_START = ADDR_W'(12'hA00);

    a_r3_oe_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe != $past(pad_oe)) |-> $past(bus_sel && bus_we));

    a_r3_out_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out != $past(pad_out)) |-> $past(bus_sel && bus_we));

    a_r4_func_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_func != $past(pin_func)) |-> $past(bus_sel && bus_we));

    a_r10_irq_falls_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_sel && bus_we));

    a_r7_pend_needs_ien: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(ien_vec)) == '0));

    a_r11_gap_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && (bus_addr >= GAP_START)) |-> (bus_rdata == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/gpio_irq_ctrl_tb_top.sv
// Bench for gpio_irq_ctrl: a table of configuration write/read vectors,
// then directed tests for outputs, detection modes, routing and clearing.
module gpio_irq_ctrl_tb_top;

    localparam int NP = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [2*NP-1:0] pin_func;
    logic          irq;
    int            n_run = 0, n_fail = 0;
    logic [31:0]   rd;

    always #2 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pin_func(pin_func), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    // Write/readback vectors for R2 (field layout) and R11 (unmapped).
    localparam vec_t VECS [7] = '{
        '{12'h00C, 32'hFFFF_FFFF, 32'h0007_026E},
        '{12'h0FC, 32'h0005_0224, 32'h0005_0224},
        '{12'h000, 32'h1234_5678, 32'h0004_0268},
        '{12'h100, 32'hFFFF_FFFF, 32'h0000_0000},
        '{12'hA00, 32'hFFFF_FFFF, 32'h0000_0000},
        '{12'h808, 32'hFFFF_FFFF, 32'h0000_0000},
        '{12'h7FC, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_pad(int p, logic v);
        @(negedge clk);
        pad_in[p] = v;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] cfgw(int mode, int func, int ien, int grp);
        return (32'(grp) << 16) | (32'(ien) << 9) | (32'(func) << 5) | (32'(mode) << 1);
    endfunction

    // Watchdog: an overrun counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state.
        bus_read(12'h000, rd); check("R1 cfg pin0", rd, 32'h0);
        bus_read(12'h014, rd); check("R1 cfg pin5", rd, 32'h0);
        bus_read(12'h800, rd); check("R1 status", rd, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 oe", pad_oe[31:0] | pad_oe[63:32], 32'h0);
        check("R1 func", pin_func[31:0], 32'h0);

        // R2 / R11 vector table.
        foreach (VECS[i]) bus_write(VECS[i].addr, VECS[i].wdata);
        foreach (VECS[i]) begin
            bus_read(VECS[i].addr, rd);
            check("R2/R11 table", rd, VECS[i].exp);
        end
        bus_read(12'h000, rd); check("R11 pin0 untouched", rd, 32'h0004_0268);
        check("R4 pin0 func", 32'(pin_func[1:0]), 32'h3);
        bus_write(12'h00C, 32'h0); bus_write(12'h0FC, 32'h0); bus_write(12'h000, 32'h0);

        // R3: output mode drives pad.
        bus_write(12'h01C, cfgw(1, 0, 0, 0) | 32'h1);
        check("R3 oe on", 32'(pad_oe[7]), 32'h1);
        check("R3 out hi", 32'(pad_out[7]), 32'h1);
        check("R3 others oe", 32'(pad_oe & ~(64'd1 << 7)), 32'h0);
        bus_write(12'h01C, cfgw(1, 0, 0, 0));
        check("R3 out lo", 32'(pad_out[7]), 32'h0);
        bus_write(12'h01C, cfgw(0, 0, 0, 0) | 32'h1);
        check("R3 oe off in input mode", 32'(pad_oe[7]), 32'h0);
        bus_write(12'h01C, 32'h0);

        // R4: function select.
        bus_write(12'h024, cfgw(0, 2, 0, 0));
        check("R4 pin9 func", 32'(pin_func[19:18]), 32'h2);

        // R2: bit 0 follows pin level.
        set_pad(12, 1'b1); edges(2);
        bus_read(12'h030, rd); check("R2 data bit", rd, 32'h1);
        set_pad(12, 1'b0);

        // R6: rising edge, latency and persistence.
        bus_write(12'h014, cfgw(4, 0, 1, 0));
        set_pad(5, 1'b1); edges(2);
        check("R6 not yet at edge 2", 32'(irq), 32'h0);
        edges(1);
        check("R6 rising set at edge 3", 32'(irq), 32'h1);
        set_pad(5, 1'b0); edges(3);
        bus_read(12'h800, rd); check("R6 rising stays", rd, 32'h20);
        bus_write(12'h800, 32'h0);
        bus_read(12'h800, rd); check("R9 zero keeps", rd, 32'h20);
        bus_write(12'h800, 32'h20);
        bus_read(12'h800, rd); check("R9 one clears", rd, 32'h0);
        check("R10 irq low", 32'(irq), 32'h0);

        // R6: falling edge ignores the rise.
        bus_write(12'h014, cfgw(5, 0, 1, 0));
        set_pad(5, 1'b1); edges(3);
        bus_read(12'h800, rd); check("R6 falling ignores rise", rd, 32'h0);
        set_pad(5, 1'b0); edges(3);
        bus_read(12'h800, rd); check("R6 falling set", rd, 32'h20);
        bus_write(12'h800, 32'h20);

        // R6: either edge.
        bus_write(12'h014, cfgw(6, 0, 1, 0));
        set_pad(5, 1'b1); edges(3);
        bus_read(12'h800, rd); check("R6 any-edge rise", rd, 32'h20);
        bus_write(12'h800, 32'h20);
        set_pad(5, 1'b0); edges(3);
        bus_read(12'h800, rd); check("R6 any-edge fall", rd, 32'h20);
        bus_write(12'h800, 32'h20);
        bus_write(12'h014, 32'h0);

        // R5 / R8: level high on pin 40, group 3.
        bus_write(12'h0A0, cfgw(2, 0, 1, 3));
        set_pad(40, 1'b1); edges(3);
        bus_read(12'h8C4, rd); check("R8 group3 word1", rd, 32'h100);
        bus_read(12'h804, rd); check("R8 group0 word1 empty", rd, 32'h0);
        bus_read(12'h8C0, rd); check("R8 group3 word0 empty", rd, 32'h0);
        check("R10 irq high", 32'(irq), 32'h1);
        bus_write(12'h8C4, 32'h100); edges(1);
        bus_read(12'h8C4, rd); check("R5 level re-sets", rd, 32'h100);
        set_pad(40, 1'b0); edges(3);
        bus_write(12'h8C4, 32'h100); edges(2);
        bus_read(12'h8C4, rd); check("R5 clear holds when inactive", rd, 32'h0);

        // R5: level low.
        bus_write(12'h0A0, cfgw(3, 0, 1, 3)); edges(2);
        bus_read(12'h8C4, rd); check("R5 level-low set", rd, 32'h100);
        set_pad(40, 1'b1); edges(3);
        bus_write(12'h8C4, 32'h100); edges(2);
        bus_read(12'h8C4, rd); check("R5 level-low cleared", rd, 32'h0);
        bus_write(12'h0A0, 32'h0);
        set_pad(40, 1'b0);

        // R7: no pending without enable, or with modes 0, 1, 7.
        bus_write(12'h014, cfgw(4, 0, 0, 0));
        set_pad(5, 1'b1); edges(3); set_pad(5, 1'b0); edges(3);
        bus_read(12'h800, rd); check("R7 enable off", rd, 32'h0);
        bus_write(12'h014, cfgw(7, 0, 1, 0));
        set_pad(5, 1'b1); edges(3); set_pad(5, 1'b0); edges(3);
        bus_read(12'h800, rd); check("R7 mode off", rd, 32'h0);
        bus_write(12'h014, cfgw(0, 0, 1, 0));
        set_pad(5, 1'b1); edges(3);
        bus_write(12'h014, cfgw(1, 0, 1, 0)); edges(2);
        bus_read(12'h800, rd); check("R7 input/output modes", rd, 32'h0);
        check("R7 irq stays low", 32'(irq), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule